// File: doc/BRIEF.md
# Boot Address Remap Decoder

This block sorts every interconnect access into one of six destinations: boot ROM, on-chip RAM, SDRAM, the FPGA bridge window, the peripheral region, or a decode error. It serves two kinds of requester. One is the processor. The other is the group of non-processor masters, which covers DMA-capable peripherals. The two kinds see different maps at low addresses. For the processor, either the boot ROM or the on-chip RAM can sit at address zero. For the other masters, either the on-chip RAM or plain SDRAM sits there. Whichever memory sits at zero hides the SDRAM bytes underneath it.

Two small register ports control the map. The remap state is changed through separate set and clear write ports, and each bit written as one changes a single bit of the state. The processor's view of SDRAM is also limited by a window. The window's lower and upper bounds are counted in whole megabytes. After reset, the lower bound is 1 MB. Any processor access between the top of the low alias and the first megabyte is therefore refused. Boot software can lower the bound once it no longer needs that protection.

The request side is a valid-only stream. The decode is purely combinational, so the block never applies back-pressure. There is no ready signal, and every cycle with `req_valid` high is decoded in that same cycle. When `req_valid` is low, the outputs are all zero.

Top module: `boot_remap_decoder`

## Requirements
- R1: After reset, the remap state is 2'b10. Bit 0 is 0, which puts the boot ROM at zero for the processor. Bit 1 is 1, which puts the on-chip RAM at zero for the other masters. The filter lower bound resets to 1 (MB) and the upper bound to 12'hC00 (the bridge base expressed in MB).
- R2: A write on the set port sets each remap bit whose set bit is 1 and leaves bits written as 0 unchanged. The new value is visible on `rmp_value` in the cycle after the write.
- R3: A write on the clear port clears each remap bit whose clear bit is 1. When the same bit is both set and cleared in one cycle, it ends up cleared.
- R4: For the processor, below 0x20000000 and outside the filter rules, the low alias works as follows. With remap bit 0 at 0, addresses below 0x20000 select the boot ROM. With remap bit 0 at 1, addresses below 0x40000 select the on-chip RAM. In both cases the offset equals the address.
- R5: For non-processor masters with remap bit 1 at 1, addresses below 0x40000 select the on-chip RAM. With bit 1 at 0, those addresses select SDRAM. The offset equals the address in both cases.
- R6: A processor address below 0xC0000000 that misses the low alias selects SDRAM when its megabyte index (address bits 31:20) is at least the lower bound and below the upper bound. The offset is then the full address. Otherwise only the decode-error bit is set and the offset is 0.
- R7: Non-processor masters reach SDRAM anywhere below 0xC0000000 outside their low alias, without filtering, and the offset is the full address.
- R8: Addresses from 0xC0000000 to 0xFEFFFFFF select the FPGA bridge for both classes, with offset equal to the address minus 0xC0000000.
- R9: Both classes also reach the memories through high aliases. Addresses 0xFFFC0000 to 0xFFFDFFFF select the boot ROM, and addresses 0xFFE00000 to 0xFFE3FFFF select the on-chip RAM. The offset is the address minus the alias base.
- R10: Any other address at or above 0xFF000000 selects the peripheral region, with offset equal to the address minus 0xFF000000.
- R11: `dec_sel` bit positions are: 0 boot ROM, 1 on-chip RAM, 2 SDRAM, 3 FPGA bridge, 4 peripheral, 5 decode error. Exactly one bit is set in the same cycle as `req_valid`. When `req_valid` is low, `dec_sel` and `dec_offset` are zero.
- R12: A filter write loads both bounds together, and the new bounds take effect in the cycle after the write. The bounds hold when no filter write occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access present this cycle |
| req_cpu | input | 1 | 1 = processor master, 0 = non-processor master |
| req_addr | input | 32 | Access address |
| rmp_set_we | input | 1 | Set-port write strobe |
| rmp_set_bits | input | 2 | Bits to set in the remap state |
| rmp_clr_we | input | 1 | Clear-port write strobe |
| rmp_clr_bits | input | 2 | Bits to clear in the remap state |
| rmp_value | output | 2 | Current remap state |
| flt_we | input | 1 | Filter bounds write strobe |
| flt_lo_mb | input | 12 | New lower bound, in MB |
| flt_hi_mb | input | 12 | New upper bound (exclusive), in MB |
| flt_lo_q | output | 12 | Current lower bound |
| flt_hi_q | output | 12 | Current upper bound |
| dec_sel | output | 6 | One-hot destination select |
| dec_offset | output | 32 | Offset within the selected region |

## Verification
The assertions cover several properties on every cycle:
- the select is one-hot under `req_valid` and quiet without it;
- a decode error arises only for the processor and carries a zero offset;
- the bridge window always wins its address range;
- set and clear writes land on the next cycle, with clear taking priority;
- the filter bounds stay put when they are not written.

Only the bench scenarios can show the exact alias boundaries, such as the 128 KB and 256 KB edges. The same holds for the 1 MB gap that appears after reset and closes once the lower bound drops. The offsets subtracted for each high alias, and the reset contents of both register ports, are likewise checked only by the scenarios.

// File: rtl/boot_remap_pkg.sv
package boot_remap_pkg;

  // Destination indices; the value is the bit position in dec_sel
  typedef enum logic [2:0] {
    TGT_ROM    = 3'd0,
    TGT_RAM    = 3'd1,
    TGT_SDRAM  = 3'd2,
    TGT_BRIDGE = 3'd3,
    TGT_PERIPH = 3'd4,
    TGT_DERR   = 3'd5
  } tgt_e;

  localparam int unsigned TGT_N = 6;

  // Remap state layout
  localparam int unsigned RMP_W       = 2;
  localparam int unsigned RMP_CPU_RAM = 0;  // 1: on-chip RAM at zero for processor
  localparam int unsigned RMP_DMA_RAM = 1;  // 1: on-chip RAM at zero for others
  localparam logic [RMP_W-1:0] RMP_RESET = 2'b10;

endpackage

// File: rtl/remap_state_reg.sv
module remap_state_reg #(
  parameter int unsigned        W   = 2,
  parameter logic [W-1:0]       RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_we,
  input  logic [W-1:0] set_bits,
  input  logic         clr_we,
  input  logic [W-1:0] clr_bits,
  output logic [W-1:0] value
);

  for (genvar b = 0; b < W; b++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        value[b] <= RST[b];
      end else if (clr_we && clr_bits[b]) begin
        value[b] <= 1'b0;
      end else if (set_we && set_bits[b]) begin
        value[b] <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/sdram_filter_reg.sv
module sdram_filter_reg #(
  parameter int unsigned     MB_W   = 12,
  parameter logic [MB_W-1:0] LO_RST = 1,
  parameter logic [MB_W-1:0] HI_RST = '1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [MB_W-1:0] lo_in,
  input  logic [MB_W-1:0] hi_in,
  output logic [MB_W-1:0] lo_q,
  output logic [MB_W-1:0] hi_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q <= LO_RST;
      hi_q <= HI_RST;
    end else if (we) begin
      lo_q <= lo_in;
      hi_q <= hi_in;
    end
  end

endmodule

// File: rtl/region_decoder.sv
module region_decoder
  import boot_remap_pkg::*;
#(
  parameter int unsigned        ADDR_W      = 32,
  parameter int unsigned        MB_SHIFT    = 20,
  parameter int unsigned        ROM_BYTES   = 'h2_0000,
  parameter int unsigned        RAM_BYTES   = 'h4_0000,
  parameter logic [ADDR_W-1:0]  BRIDGE_BASE = 'hC000_0000,
  parameter logic [ADDR_W-1:0]  PERIPH_BASE = 'hFF00_0000,
  parameter logic [ADDR_W-1:0]  RAM_HI_BASE = 'hFFE0_0000,
  parameter logic [ADDR_W-1:0]  ROM_HI_BASE = 'hFFFC_0000,
  localparam int unsigned       MB_W        = ADDR_W - MB_SHIFT
) (
  input  logic              valid,
  input  logic              is_cpu,
  input  logic [ADDR_W-1:0] addr,
  input  logic [RMP_W-1:0]  rmp,
  input  logic [MB_W-1:0]   flt_lo,
  input  logic [MB_W-1:0]   flt_hi,
  output logic [TGT_N-1:0]  sel,
  output logic [ADDR_W-1:0] offset
);

  localparam logic [ADDR_W-1:0] ROM_LIM    = ADDR_W'(ROM_BYTES);
  localparam logic [ADDR_W-1:0] RAM_LIM    = ADDR_W'(RAM_BYTES);
  localparam logic [ADDR_W-1:0] ROM_HI_END = ROM_HI_BASE + ROM_LIM;
  localparam logic [ADDR_W-1:0] RAM_HI_END = RAM_HI_BASE + RAM_LIM;

  tgt_e              tgt;
  logic [ADDR_W-1:0] off_raw;
  logic [MB_W-1:0]   mb_idx;
  logic              in_window;
  logic              low_rom, low_ram_cpu, low_ram_dma;

  assign mb_idx      = addr[ADDR_W-1:MB_SHIFT];
  assign in_window   = (mb_idx >= flt_lo) && (mb_idx < flt_hi);
  assign low_rom     = !rmp[RMP_CPU_RAM] && (addr < ROM_LIM);
  assign low_ram_cpu =  rmp[RMP_CPU_RAM] && (addr < RAM_LIM);
  assign low_ram_dma =  rmp[RMP_DMA_RAM] && (addr < RAM_LIM);

  always_comb begin
    tgt     = TGT_DERR;
    off_raw = '0;
    if (addr >= PERIPH_BASE) begin
      if (addr >= ROM_HI_BASE && addr < ROM_HI_END) begin
        tgt     = TGT_ROM;
        off_raw = addr - ROM_HI_BASE;
      end else if (addr >= RAM_HI_BASE && addr < RAM_HI_END) begin
        tgt     = TGT_RAM;
        off_raw = addr - RAM_HI_BASE;
      end else begin
        tgt     = TGT_PERIPH;
        off_raw = addr - PERIPH_BASE;
      end
    end else if (addr >= BRIDGE_BASE) begin
      tgt     = TGT_BRIDGE;
      off_raw = addr - BRIDGE_BASE;
    end else if (is_cpu) begin
      if (low_rom) begin
        tgt     = TGT_ROM;
        off_raw = addr;
      end else if (low_ram_cpu) begin
        tgt     = TGT_RAM;
        off_raw = addr;
      end else if (in_window) begin
        tgt     = TGT_SDRAM;
        off_raw = addr;
      end
    end else begin
      tgt     = low_ram_dma ? TGT_RAM : TGT_SDRAM;
      off_raw = addr;
    end
  end

  always_comb begin
    sel    = '0;
    offset = '0;
    if (valid) begin
      sel[int'(tgt)] = 1'b1;
      offset         = off_raw;
    end
  end

endmodule

// File: rtl/boot_remap_decoder.sv
module boot_remap_decoder
  import boot_remap_pkg::*;
#(
  parameter int unsigned       ADDR_W      = 32,
  parameter int unsigned       MB_SHIFT    = 20,
  parameter int unsigned       ROM_BYTES   = 'h2_0000,
  parameter int unsigned       RAM_BYTES   = 'h4_0000,
  parameter logic [ADDR_W-1:0] BRIDGE_BASE = 'hC000_0000,
  parameter logic [ADDR_W-1:0] PERIPH_BASE = 'hFF00_0000,
  parameter logic [ADDR_W-1:0] RAM_HI_BASE = 'hFFE0_0000,
  parameter logic [ADDR_W-1:0] ROM_HI_BASE = 'hFFFC_0000,
  localparam int unsigned      MB_W        = ADDR_W - MB_SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_cpu,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              rmp_set_we,
  input  logic [RMP_W-1:0]  rmp_set_bits,
  input  logic              rmp_clr_we,
  input  logic [RMP_W-1:0]  rmp_clr_bits,
  output logic [RMP_W-1:0]  rmp_value,
  input  logic              flt_we,
  input  logic [MB_W-1:0]   flt_lo_mb,
  input  logic [MB_W-1:0]   flt_hi_mb,
  output logic [MB_W-1:0]   flt_lo_q,
  output logic [MB_W-1:0]   flt_hi_q,
  output logic [TGT_N-1:0]  dec_sel,
  output logic [ADDR_W-1:0] dec_offset
);

  localparam logic [MB_W-1:0] FLT_LO_RST = MB_W'(1);
  localparam logic [MB_W-1:0] FLT_HI_RST = BRIDGE_BASE[ADDR_W-1:MB_SHIFT];

  remap_state_reg #(
    .W   (RMP_W),
    .RST (RMP_RESET)
  ) i_remap (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_we   (rmp_set_we),
    .set_bits (rmp_set_bits),
    .clr_we   (rmp_clr_we),
    .clr_bits (rmp_clr_bits),
    .value    (rmp_value)
  );

  sdram_filter_reg #(
    .MB_W   (MB_W),
    .LO_RST (FLT_LO_RST),
    .HI_RST (FLT_HI_RST)
  ) i_filter (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (flt_we),
    .lo_in (flt_lo_mb),
    .hi_in (flt_hi_mb),
    .lo_q  (flt_lo_q),
    .hi_q  (flt_hi_q)
  );

  region_decoder #(
    .ADDR_W      (ADDR_W),
    .MB_SHIFT    (MB_SHIFT),
    .ROM_BYTES   (ROM_BYTES),
    .RAM_BYTES   (RAM_BYTES),
    .BRIDGE_BASE (BRIDGE_BASE),
    .PERIPH_BASE (PERIPH_BASE),
    .RAM_HI_BASE (RAM_HI_BASE),
    .ROM_HI_BASE (ROM_HI_BASE)
  ) i_decode (
    .valid  (req_valid),
    .is_cpu (req_cpu),
    .addr   (req_addr),
    .rmp    (rmp_value),
    .flt_lo (flt_lo_q),
    .flt_hi (flt_hi_q),
    .sel    (dec_sel),
    .offset (dec_offset)
  );

endmodule

// File: rtl/boot_remap_chk.sv
module boot_remap_chk
  import boot_remap_pkg::*;
#(
  parameter int unsigned       ADDR_W      = 32,
  parameter int unsigned       MB_W        = 12,
  parameter logic [ADDR_W-1:0] BRIDGE_BASE = 'hC000_0000,
  parameter logic [ADDR_W-1:0] PERIPH_BASE = 'hFF00_0000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_cpu,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rmp_set_we,
  input logic [RMP_W-1:0]  rmp_set_bits,
  input logic              rmp_clr_we,
  input logic [RMP_W-1:0]  rmp_clr_bits,
  input logic [RMP_W-1:0]  rmp_value,
  input logic              flt_we,
  input logic [MB_W-1:0]   flt_lo_q,
  input logic [MB_W-1:0]   flt_hi_q,
  input logic [TGT_N-1:0]  dec_sel,
  input logic [ADDR_W-1:0] dec_offset
);

  // R11
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> $countones(dec_sel) == 1);

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (dec_sel == '0) && (dec_offset == '0));

  // R2
  set_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rmp_set_we && !rmp_clr_we) |=> rmp_value == ($past(rmp_value) | $past(rmp_set_bits)));

  // R3
  clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rmp_clr_we |=> (rmp_value & $past(rmp_clr_bits)) == '0);

  // R6
  derr_cpu_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_sel[TGT_DERR] |-> req_cpu && (dec_offset == '0));

  // R8
  bridge_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_addr >= BRIDGE_BASE && req_addr < PERIPH_BASE) |-> dec_sel[TGT_BRIDGE]);

  // R12
  flt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !flt_we |=> $stable(flt_lo_q) && $stable(flt_hi_q));

endmodule

bind boot_remap_decoder boot_remap_chk #(
  .ADDR_W      (ADDR_W),
  .MB_W        (MB_W),
  .BRIDGE_BASE (BRIDGE_BASE),
  .PERIPH_BASE (PERIPH_BASE)
) i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_cpu      (req_cpu),
  .req_addr     (req_addr),
  .rmp_set_we   (rmp_set_we),
  .rmp_set_bits (rmp_set_bits),
  .rmp_clr_we   (rmp_clr_we),
  .rmp_clr_bits (rmp_clr_bits),
  .rmp_value    (rmp_value),
  .flt_we       (flt_we),
  .flt_lo_q     (flt_lo_q),
  .flt_hi_q     (flt_hi_q),
  .dec_sel      (dec_sel),
  .dec_offset   (dec_offset)
);

// File: tb/test_boot_remap_decoder.sv
`timescale 1ns/1ps
module test_boot_remap_decoder;

  localparam logic [5:0] S_ROM = 6'h01, S_RAM = 6'h02, S_SD = 6'h04,
                         S_BR  = 6'h08, S_PE  = 6'h10, S_DE = 6'h20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_cpu = 1'b0;
  logic [31:0] req_addr = '0;
  logic        rmp_set_we = 1'b0, rmp_clr_we = 1'b0;
  logic [1:0]  rmp_set_bits = '0, rmp_clr_bits = '0, rmp_value;
  logic        flt_we = 1'b0;
  logic [11:0] flt_lo_mb = '0, flt_hi_mb = '0, flt_lo_q, flt_hi_q;
  logic [5:0]  dec_sel;
  logic [31:0] dec_offset;

  int errs = 0;
  int nchk = 0;

  typedef struct {
    logic [5:0]  sel;
    logic [31:0] off;
    string       tag;
  } exp_t;
  exp_t exq[$];

  always #2.5 clk = ~clk;

  boot_remap_decoder i_boot_remap_decoder (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cpu(req_cpu),
    .req_addr(req_addr), .rmp_set_we(rmp_set_we), .rmp_set_bits(rmp_set_bits),
    .rmp_clr_we(rmp_clr_we), .rmp_clr_bits(rmp_clr_bits), .rmp_value(rmp_value),
    .flt_we(flt_we), .flt_lo_mb(flt_lo_mb), .flt_hi_mb(flt_hi_mb),
    .flt_lo_q(flt_lo_q), .flt_hi_q(flt_hi_q), .dec_sel(dec_sel),
    .dec_offset(dec_offset)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    nchk++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver: applies one access and queues its expected result
  task automatic send(input logic v, input logic cpu, input logic [31:0] a,
                      input logic [5:0] es, input logic [31:0] eo, input string tag);
    exp_t e;
    @(posedge clk); #1;
    req_valid = v;
    req_cpu   = cpu;
    req_addr  = a;
    e.sel = es; e.off = eo; e.tag = tag;
    exq.push_back(e);
  endtask

  task automatic wr_remap(input logic sw, input logic [1:0] sb,
                          input logic cw, input logic [1:0] cb);
    @(posedge clk); #1;
    rmp_set_we = sw; rmp_set_bits = sb;
    rmp_clr_we = cw; rmp_clr_bits = cb;
    @(posedge clk); #1;
    rmp_set_we = 1'b0; rmp_clr_we = 1'b0;
  endtask

  task automatic wr_filter(input logic [11:0] lo, input logic [11:0] hi);
    @(posedge clk); #1;
    flt_we = 1'b1; flt_lo_mb = lo; flt_hi_mb = hi;
    @(posedge clk); #1;
    flt_we = 1'b0;
  endtask

  // Monitor: compares outputs away from the clock edge
  initial begin
    forever begin
      @(negedge clk); #1;
      if (exq.size() > 0) begin
        exp_t e;
        e = exq.pop_front();
        check({26'd0, dec_sel}, {26'd0, e.sel}, {e.tag, " sel"});
        check(dec_offset, e.off, {e.tag, " offset"});
      end
    end
  end

  initial begin
    #500000;
    errs++;
    nchk++;
    $display("FAIL R11 watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errs, nchk);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    check({30'd0, rmp_value}, 32'h2, "R1 remap reset");
    check({20'd0, flt_lo_q}, 32'h1, "R1 filter lo reset");
    check({20'd0, flt_hi_q}, 32'hC00, "R1 filter hi reset");

    send(1, 1, 32'h0000_1000, S_ROM, 32'h0000_1000, "R4 cpu rom low");
    send(1, 1, 32'h0001_FFFF, S_ROM, 32'h0001_FFFF, "R4 cpu rom top");
    send(1, 1, 32'h0002_0000, S_DE,  32'h0,         "R6 cpu gap start");
    send(1, 1, 32'h000F_FFFF, S_DE,  32'h0,         "R6 cpu gap end");
    send(1, 1, 32'h0010_0000, S_SD,  32'h0010_0000, "R6 cpu sdram 1MB");
    send(1, 1, 32'hBFFF_FFFF, S_SD,  32'hBFFF_FFFF, "R6 cpu sdram top");
    send(1, 0, 32'h0003_FFFF, S_RAM, 32'h0003_FFFF, "R5 dma ram top");
    send(1, 0, 32'h0004_0000, S_SD,  32'h0004_0000, "R7 dma sdram");
    send(1, 1, 32'hC000_0010, S_BR,  32'h0000_0010, "R8 cpu bridge");
    send(1, 0, 32'hFEFF_FFFC, S_BR,  32'h3EFF_FFFC, "R8 dma bridge top");
    send(1, 1, 32'hFFFC_0004, S_ROM, 32'h0000_0004, "R9 cpu rom high");
    send(1, 0, 32'hFFE0_0100, S_RAM, 32'h0000_0100, "R9 dma ram high");
    send(1, 1, 32'hFF20_0000, S_PE,  32'h0020_0000, "R10 cpu periph");
    send(1, 1, 32'hFFFE_0000, S_PE,  32'h00FE_0000, "R10 past rom alias");
    send(0, 1, 32'h0000_1000, 6'h0,  32'h0,         "R11 idle");
    repeat (2) @(posedge clk);

    wr_remap(1, 2'b01, 0, 2'b00);
    check({30'd0, rmp_value}, 32'h3, "R2 set bit0");
    send(1, 1, 32'h0002_0000, S_RAM, 32'h0002_0000, "R4 cpu ram low");
    send(1, 1, 32'h0003_FFFC, S_RAM, 32'h0003_FFFC, "R4 cpu ram top");
    send(1, 1, 32'h0004_0000, S_DE,  32'h0,         "R6 cpu gap after ram");
    send(0, 1, 32'h0, 6'h0, 32'h0, "R11 idle");
    repeat (2) @(posedge clk);

    wr_remap(1, 2'b00, 0, 2'b00);
    check({30'd0, rmp_value}, 32'h3, "R2 zero set no change");
    wr_remap(1, 2'b10, 1, 2'b10);
    check({30'd0, rmp_value}, 32'h1, "R3 clear beats set");
    send(1, 0, 32'h0000_0100, S_SD, 32'h0000_0100, "R5 dma sdram at zero");
    send(0, 0, 32'h0, 6'h0, 32'h0, "R11 idle");
    repeat (2) @(posedge clk);

    wr_remap(0, 2'b00, 1, 2'b01);
    check({30'd0, rmp_value}, 32'h0, "R3 clear bit0");
    send(1, 1, 32'h0000_0100, S_ROM, 32'h0000_0100, "R4 cpu rom back");
    send(1, 1, 32'hFFFC_0000, S_ROM, 32'h0,         "R9 rom high base");
    send(1, 1, 32'hFFE3_FFFC, S_RAM, 32'h0003_FFFC, "R9 ram high top");
    send(0, 1, 32'h0, 6'h0, 32'h0, "R11 idle");
    repeat (2) @(posedge clk);

    wr_filter(12'h000, 12'h800);
    check({20'd0, flt_lo_q}, 32'h0,   "R12 filter lo");
    check({20'd0, flt_hi_q}, 32'h800, "R12 filter hi");
    send(1, 1, 32'h0002_0000, S_SD, 32'h0002_0000, "R12 cpu low sdram opened");
    send(1, 1, 32'h7FFF_FFFC, S_SD, 32'h7FFF_FFFC, "R6 below hi bound");
    send(1, 1, 32'h8000_0000, S_DE, 32'h0,         "R6 at hi bound");
    send(1, 0, 32'h8000_0000, S_SD, 32'h8000_0000, "R7 dma unfiltered");
    send(0, 0, 32'h0, 6'h0, 32'h0, "R11 idle");
    repeat (4) @(posedge clk);

    $display("Result: errors=%0d of %0d checks", errs, nchk);
    $finish;
  end

endmodule